// File: doc/BRIEF.md
# Active-Low Interrupt and Event Aggregator

This block gathers the state of seven bus interrupt request lines, a message-ready condition and a group of system event conditions, and reduces them to one level-sensitive host interrupt. Every status bit is active-low: a condition is present when its bit reads 0. Software reaches four byte-wide registers through a small port with a 2-bit address, a write strobe, 8-bit write data and combinational read data. The four registers are interrupt state at address 0 (read-only), interrupt enable at address 1, event state at address 2 and event enable at address 3.

Most state bits follow their live inputs. Two event bits are sticky: the bus-error flag and the reset-event flag. Each is driven to 0 by its event, is forced to read 0 while its reset condition is active, and is released only when software writes 1 to it. The host interrupt is a register. It is set one clock after any enabled state bit reads 0.

Top module: `irq_event_agg`

## Requirements
- R1: Interrupt state (address 0) bits 7..1 show request lines 7..1 in the same polarity, where line k is `irq_line_n[k-1]`. A bit reads 0 while its line is asserted low.
- R2: Bit 0 of interrupt state is the message bit. It reads 0 exactly when both `rsp_rd_rdy` and `rsp_wr_rdy` are 0.
- R3: Event state (address 2) reads 1 in bits 7 and 6. Its live bits read 0 while their condition is high: bit 4 FIFO not empty, bit 3 watchdog expired, bit 2 AC fail, bit 0 system fail. Writes do not change these bits.
- R4: After block reset both enable registers read 0x00 and `host_irq` is 0. A write to address 1 or 3 is read back unchanged.
- R5: `host_irq` becomes 1 on the clock edge after any bit of interrupt state is 0 with its address-1 enable bit set, or any of event state bits 5..0 is 0 with its address-3 enable bit set. Otherwise it becomes 0 on that edge. Event enable bits 7..6 have no effect.
- R6: A one-cycle `bus_err` pulse clears event bit 1 on the next edge. The bit stays 0 until a write to address 2 with data bit 1 set.
- R7: While `soft_reset` is 1, event bit 1 reads 0 at once, and a write-1 to it has no effect. It stays 0 after `soft_reset` falls, until a write-1 clears it.
- R8: Event bit 5 (reset event) is 0 after block reset. It goes to 0 when `sys_reset` or `soft_reset` is 1, and reads 0 at once while either is 1. A write to address 2 with data bit 5 set releases it to 1 only when both are 0.
- R9: Writing 0 to bit 1 or bit 5 of address 2 has no effect. If `bus_err` and a write-1 to bit 1 fall in the same cycle, bit 1 stays 0.
- R10: A write to address 0 changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous block reset, active low |
| irq_line_n | input | 7 | Bus request lines 1..7 (index 0 = line 1), active low |
| rsp_rd_rdy | input | 1 | Response read-ready flag |
| rsp_wr_rdy | input | 1 | Response write-ready flag |
| sys_fail | input | 1 | System fail condition, active high |
| ac_fail | input | 1 | AC fail condition, active high |
| wdog_expired | input | 1 | Watchdog expired, active high |
| fifo_nempty | input | 1 | Signal FIFO not empty, active high |
| bus_err | input | 1 | Pulse: outgoing access ended in a bus error |
| sys_reset | input | 1 | System reset in progress, active high |
| soft_reset | input | 1 | Soft reset control, active high |
| reg_addr | input | 2 | Register address |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for `reg_addr` |
| host_irq | output | 1 | Registered host interrupt |

## Verification
Read data is combinational: live bits and the hold on the two sticky bits show in the same cycle their input changes. Sticky-bit updates and enable writes show one edge after the strobe or pulse. `host_irq` comes one register later than its cause, so a cause that the bench drives after a falling edge shows at the next rising edge. The bench drives inputs just after falling edges and samples a quarter period after each rising edge. There it compares `host_irq` and the read data with a reference model that steps on the same edge. Directed checks sample the interrupt on the falling edge before its edge, to confirm it is still low, and again after that edge, to confirm it has risen.

// File: rtl/agg_pkg.sv
package agg_pkg;
    localparam int DATA_W    = 8;
    localparam int NUM_LINES = 7;
    localparam int EVT_USED  = 6;
    localparam int NUM_STICKY = 2;

    typedef enum logic [1:0] {
        ADDR_ISTATE = 2'd0,
        ADDR_IMASK  = 2'd1,
        ADDR_ESTATE = 2'd2,
        ADDR_EMASK  = 2'd3
    } reg_addr_e;

    // event state bit positions (decoded by software)
    localparam int EB_SYSF = 0;
    localparam int EB_BERR = 1;
    localparam int EB_ACF  = 2;
    localparam int EB_WDT  = 3;
    localparam int EB_FIFO = 4;
    localparam int EB_REVT = 5;

    // sticky slot indices
    localparam int SK_BERR = 0;
    localparam int SK_REVT = 1;

    typedef struct packed {
        logic [DATA_W-1:0] imask;
        logic [DATA_W-1:0] emask;
        logic              irq;
    } agg_regs_t;
endpackage

// File: rtl/agg_sticky_flag.sv
module agg_sticky_flag #(
    parameter logic INIT = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic hold_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_i) begin
            flag_d = 1'b0;
        end else if (clr_i && !hold_i) begin
            flag_d = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= INIT;
        else        flag_q <= flag_d;
    end

    assign flag_o = flag_q & ~hold_i;

    assert_event_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> !flag_q);

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_i && !clr_i) |=> $stable(flag_q));

    assert_release_by_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> ($past(clr_i) && !$past(set_i) && !$past(hold_i)));
endmodule

// File: rtl/agg_irq_mask.sv
module agg_irq_mask #(
    parameter int W = 8
) (
    input  logic [W-1:0] state_n_i,
    input  logic [W-1:0] enable_i,
    output logic         any_o
);
    assign any_o = |(~state_n_i & enable_i);
endmodule

// File: rtl/irq_event_agg.sv
module irq_event_agg
    import agg_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] irq_line_n,
    input  logic                 rsp_rd_rdy,
    input  logic                 rsp_wr_rdy,
    input  logic                 sys_fail,
    input  logic                 ac_fail,
    input  logic                 wdog_expired,
    input  logic                 fifo_nempty,
    input  logic                 bus_err,
    input  logic                 sys_reset,
    input  logic                 soft_reset,
    input  logic [1:0]           reg_addr,
    input  logic                 reg_wr,
    input  logic [DATA_W-1:0]    reg_wdata,
    output logic [DATA_W-1:0]    reg_rdata,
    output logic                 host_irq
);
    agg_regs_t regs_d, regs_q;

    logic [DATA_W-1:0]     istate_n;
    logic [DATA_W-1:0]     estate_n;
    logic [NUM_STICKY-1:0] sk_set, sk_hold, sk_clr, sk_flag;
    logic                  wr_estate;
    logic                  any_int, any_evt;

    assign wr_estate = reg_wr && (reg_addr == ADDR_ESTATE);

    // sticky inputs per slot
    always_comb begin
        sk_set[SK_BERR]  = bus_err | soft_reset;
        sk_hold[SK_BERR] = soft_reset;
        sk_clr[SK_BERR]  = wr_estate & reg_wdata[EB_BERR];
        sk_set[SK_REVT]  = sys_reset | soft_reset;
        sk_hold[SK_REVT] = sys_reset | soft_reset;
        sk_clr[SK_REVT]  = wr_estate & reg_wdata[EB_REVT];
    end

    localparam logic [NUM_STICKY-1:0] STICKY_INIT = 2'b01; // berr=1, revt=0

    for (genvar s = 0; s < NUM_STICKY; s++) begin : g_sticky
        agg_sticky_flag #(.INIT(STICKY_INIT[s])) u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (sk_set[s]),
            .hold_i (sk_hold[s]),
            .clr_i  (sk_clr[s]),
            .flag_o (sk_flag[s])
        );
    end

    // active-low state views
    assign istate_n = {irq_line_n, (rsp_rd_rdy | rsp_wr_rdy)};

    always_comb begin
        estate_n                         = '1;
        estate_n[EB_SYSF]                = ~sys_fail;
        estate_n[EB_BERR]                = sk_flag[SK_BERR];
        estate_n[EB_ACF]                 = ~ac_fail;
        estate_n[EB_WDT]                 = ~wdog_expired;
        estate_n[EB_FIFO]                = ~fifo_nempty;
        estate_n[EB_REVT]                = sk_flag[SK_REVT];
    end

    agg_irq_mask #(.W(DATA_W)) u_mask_int (
        .state_n_i (istate_n),
        .enable_i  (regs_q.imask),
        .any_o     (any_int)
    );

    agg_irq_mask #(.W(EVT_USED)) u_mask_evt (
        .state_n_i (estate_n[EVT_USED-1:0]),
        .enable_i  (regs_q.emask[EVT_USED-1:0]),
        .any_o     (any_evt)
    );

    always_comb begin
        regs_d     = regs_q;
        regs_d.irq = any_int | any_evt;
        if (reg_wr) begin
            case (reg_addr)
                ADDR_IMASK: regs_d.imask = reg_wdata;
                ADDR_EMASK: regs_d.emask = reg_wdata;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    always_comb begin
        case (reg_addr)
            ADDR_ISTATE: reg_rdata = istate_n;
            ADDR_IMASK:  reg_rdata = regs_q.imask;
            ADDR_ESTATE: reg_rdata = estate_n;
            default:     reg_rdata = regs_q.emask;
        endcase
    end

    assign host_irq = regs_q.irq;

    assert_irq_one_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ##1 (host_irq == $past(any_int | any_evt)));

    assert_msg_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rsp_rd_rdy && !rsp_wr_rdy && reg_addr == ADDR_ISTATE) |-> !reg_rdata[0]);

    assert_hold_reads_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (soft_reset && reg_addr == ADDR_ESTATE) |-> !reg_rdata[EB_BERR]);

    assert_state_write_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == ADDR_ISTATE) |=> ($stable(regs_q.imask) && $stable(regs_q.emask)));

    assert_top_bits_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_ESTATE) |-> (reg_rdata[7:6] == 2'b11));
endmodule

// File: tb/irq_event_agg_tb.sv
module irq_event_agg_tb_top;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 0;
    logic       rst_n = 0;
    logic [6:0] irq_line_n = 7'h7F;
    logic       rsp_rd_rdy = 1, rsp_wr_rdy = 0;
    logic       sys_fail = 0, ac_fail = 0, wdog_expired = 0, fifo_nempty = 0;
    logic       bus_err = 0, sys_reset = 0, soft_reset = 0;
    logic [1:0] reg_addr = 0;
    logic       reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic       host_irq;

    int checks = 0;
    int errors = 0;

    irq_event_agg dut_i (
        .clk(clk), .rst_n(rst_n), .irq_line_n(irq_line_n),
        .rsp_rd_rdy(rsp_rd_rdy), .rsp_wr_rdy(rsp_wr_rdy),
        .sys_fail(sys_fail), .ac_fail(ac_fail), .wdog_expired(wdog_expired),
        .fifo_nempty(fifo_nempty), .bus_err(bus_err), .sys_reset(sys_reset),
        .soft_reset(soft_reset), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .host_irq(host_irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // reference model state
    logic [7:0] m_imask = 0, m_emask = 0;
    logic       m_berr = 1, m_revt = 0, m_irq = 0;

    function automatic logic [7:0] m_istate();
        return {irq_line_n, rsp_rd_rdy | rsp_wr_rdy};
    endfunction

    function automatic logic [7:0] m_estate();
        return {2'b11, m_revt & ~sys_reset & ~soft_reset, ~fifo_nempty,
                ~wdog_expired, ~ac_fail, m_berr & ~soft_reset, ~sys_fail};
    endfunction

    function automatic logic [7:0] m_read(input logic [1:0] a);
        case (a)
            2'd0: return m_istate();
            2'd1: return m_imask;
            2'd2: return m_estate();
            default: return m_emask;
        endcase
    endfunction

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%02h exp=%02h at %0t", tag, got, exp, $time);
        end
    endtask

    // per-clock model step and compare
    always @(posedge clk) begin
        if (!rst_n) begin
            m_imask = 0; m_emask = 0; m_berr = 1; m_revt = 0; m_irq = 0;
        end else begin
            logic nxt;
            logic [7:0] es;
            es  = m_estate();
            nxt = (|(~m_istate() & m_imask)) | (|(~es[5:0] & m_emask[5:0]));
            if (soft_reset || bus_err) m_berr = 0;
            else if (reg_wr && reg_addr == 2 && reg_wdata[1]) m_berr = 1;
            if (sys_reset || soft_reset) m_revt = 0;
            else if (reg_wr && reg_addr == 2 && reg_wdata[5]) m_revt = 1;
            if (reg_wr && reg_addr == 1) m_imask = reg_wdata;
            if (reg_wr && reg_addr == 3) m_emask = reg_wdata;
            m_irq = nxt;
            #(CLK_PERIOD/4);
            check("R5 model irq", {7'd0, host_irq}, {7'd0, m_irq});
            check("R1/R3 model read", reg_rdata, m_read(reg_addr));
        end
    end

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input string tag, input logic [1:0] a, input logic [7:0] exp);
        @(negedge clk);
        reg_addr = a; reg_wr = 0;
        @(posedge clk);
        #(CLK_PERIOD/4);
        check(tag, reg_rdata, exp);
    endtask

    task automatic irq_is(input string tag, input logic exp);
        @(posedge clk);
        #(CLK_PERIOD/4);
        check(tag, {7'd0, host_irq}, {7'd0, exp});
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        // R4 reset state
        rd("R4 imask reset", 2'd1, 8'h00);
        rd("R4 emask reset", 2'd3, 8'h00);
        check("R4 irq reset", {7'd0, host_irq}, 8'h00);
        rd("R1 idle istate", 2'd0, 8'hFF);
        rd("R8 revt after reset", 2'd2, 8'hDF);

        // R1 lines
        @(negedge clk); irq_line_n = 7'b1011010;
        rd("R1 line pattern", 2'd0, 8'hB5);
        // R2 message
        @(negedge clk); rsp_rd_rdy = 0;
        rd("R2 msg both low", 2'd0, 8'hB4);
        @(negedge clk); rsp_wr_rdy = 1;
        rd("R2 msg wr high", 2'd0, 8'hB5);
        @(negedge clk); irq_line_n = 7'h7F; rsp_wr_rdy = 0; rsp_rd_rdy = 1;

        // R3 live bits, writes ignored
        @(negedge clk); ac_fail = 1; wdog_expired = 1;
        rd("R3 live bits", 2'd2, 8'hD3);
        wr(2'd2, 8'h00);
        rd("R3 R9 write zero ignored", 2'd2, 8'hD3);
        wr(2'd2, 8'h20);
        rd("R8 revt released", 2'd2, 8'hF3);
        @(negedge clk); ac_fail = 0; wdog_expired = 0; fifo_nempty = 1; sys_fail = 1;
        rd("R3 fifo sysf", 2'd2, 8'hEE);
        @(negedge clk); fifo_nempty = 0; sys_fail = 0;

        // R4/R5 enables and timing
        wr(2'd1, 8'h01);
        rd("R4 imask readback", 2'd1, 8'h01);
        check("R5 no irq msg high", {7'd0, host_irq}, 8'h00);
        @(negedge clk); rsp_rd_rdy = 0;
        #1 check("R5 irq not yet", {7'd0, host_irq}, 8'h00);
        irq_is("R5 irq one edge later", 1'b1);
        @(negedge clk); rsp_rd_rdy = 1;
        irq_is("R5 irq drops", 1'b0);
        wr(2'd1, 8'h00);
        wr(2'd3, 8'hC0);
        rd("R4 emask readback", 2'd3, 8'hC0);
        irq_is("R5 top enable bits inert", 1'b0);

        // R6 bus error sticky
        wr(2'd3, 8'h02);
        @(negedge clk); bus_err = 1;
        @(negedge clk); bus_err = 0; reg_addr = 2'd2;
        #1 check("R6 berr sticky", reg_rdata, 8'hFD);
        irq_is("R6 berr raises irq", 1'b1);
        repeat (3) @(negedge clk);
        rd("R6 berr stays", 2'd2, 8'hFD);
        wr(2'd2, 8'hDD);
        rd("R9 write zero to berr", 2'd2, 8'hFD);
        wr(2'd2, 8'h02);
        rd("R6 berr cleared", 2'd2, 8'hFF);
        irq_is("R6 irq gone", 1'b0);

        // R9 error wins over clear
        @(negedge clk); reg_addr = 2'd2; reg_wdata = 8'h02; reg_wr = 1; bus_err = 1;
        @(negedge clk); reg_wr = 0; bus_err = 0;
        #1 check("R9 error wins", reg_rdata, 8'hFD);
        wr(2'd2, 8'h02);

        // R7 soft reset
        @(negedge clk); soft_reset = 1; reg_addr = 2'd2;
        #1 check("R7 hold immediate", reg_rdata, 8'hDD);
        wr(2'd2, 8'h22);
        rd("R7 clear under hold ignored", 2'd2, 8'hDD);
        @(negedge clk); soft_reset = 0;
        rd("R7 stays low after release", 2'd2, 8'hDD);
        wr(2'd2, 8'h22);
        rd("R7 R8 cleared after release", 2'd2, 8'hFF);

        // R8 system reset
        wr(2'd3, 8'h20);
        @(negedge clk); sys_reset = 1; reg_addr = 2'd2;
        #1 check("R8 revt immediate", reg_rdata, 8'hDF);
        wr(2'd2, 8'h20);
        rd("R8 clear under reset ignored", 2'd2, 8'hDF);
        irq_is("R8 revt irq", 1'b1);
        @(negedge clk); sys_reset = 0;
        rd("R8 stays after release", 2'd2, 8'hDF);
        wr(2'd2, 8'h20);
        rd("R8 released", 2'd2, 8'hFF);

        // R10 write to state address
        wr(2'd1, 8'h5A);
        wr(2'd0, 8'h00);
        rd("R10 imask untouched", 2'd1, 8'h5A);
        rd("R10 emask untouched", 2'd3, 8'h20);
        rd("R10 istate unchanged", 2'd0, 8'hFF);

        repeat (3) @(negedge clk);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule